// File: doc/BRIEF.md
# Vector Byte Table Lookup Unit

The unit resolves eight byte indices against a lookup table built from consecutive 128-bit vector registers. The registers sit in an internal file of 32 entries, which is loaded through its own write port. A lookup is launched with a start pulse. That pulse captures four operands: a 64-bit word of byte indices, the first register of the table, the number of registers in the table, and a 64-bit starting result.

The unit resolves one index byte per clock, lane 0 first. For each lane whose index falls inside the table, the matching table byte replaces that lane's byte of the result. Lanes whose index falls outside the table keep their byte from the starting result. The same datapath therefore serves two variants. A zeroing lookup passes an all-zero starting result. A merging lookup passes the old destination contents. The table may run past the last register, in which case it continues from register 0. One done pulse marks the finished result, and the result then holds until the next accepted start.

Top module: `byte_tbl_lookup`

## Requirements
- R1: While reset is asserted and after its release, busy_o and done_o are 0 and result_o is all zeros.
- R2: A start_i sampled while busy_o is 0 is accepted. The captured operands are idx_i, base_i, count_i and init_i. busy_o is then 1 for exactly eight cycles. In the cycle after the last of those, done_o is 1 for one cycle and busy_o is 0.
- R3: A start_i sampled while busy_o is 1 is ignored. The running lookup keeps its captured operands, and no second lookup follows it.
- R4: An index byte v is in range only when v < 16 * count_i. The lane of an out-of-range index keeps the byte of init_i at the same lane position.
- R5: For an in-range index v, the 64-bit element number is e = (2*base_i + (v >> 3)) mod 64. The register read is e >> 1. Even e selects register bits [63:0] and odd e selects bits [127:64]. Within that half, the byte taken is bits [8*k+7 : 8*k], where k = v[2:0].
- R6: Because e is taken mod 64, a table that starts near register 31 continues at register 0.
- R7: The index in lane n occupies idx_i bits [8n+7:8n]. The looked-up byte is written to result_o bits [8n+7:8n]. Lanes are resolved in order from n = 0 to n = 7.
- R8: A write with wr_en_i = 1 and busy_o = 0 stores wr_data_i into register wr_addr_i at the clock edge. That register is then visible to a lookup accepted in the same cycle. A write presented while busy_o is 1 is dropped.
- R9: After done_o, result_o holds its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register file write enable |
| wr_addr_i | input | 5 | Register file write address |
| wr_data_i | input | 128 | Register file write data |
| start_i | input | 1 | Lookup request |
| idx_i | input | 64 | Eight index bytes, lane 0 in bits [7:0] |
| base_i | input | 5 | First table register |
| count_i | input | 3 | Number of table registers (1 to 4) |
| init_i | input | 64 | Starting result (zeros or old destination) |
| busy_o | output | 1 | Lookup in progress |
| done_o | output | 1 | One-cycle pulse, result complete |
| result_o | output | 64 | Lookup result |

## Verification
Two functions can meet in one cycle: a register-file write and the lookup that reads that file. The bench provokes this twice. First, it presents a write in the same cycle as an accepted start, and the lookup must return the new register contents. Second, it presents a write to a table register in the middle of a running lookup. That lookup must return the old bytes, and a later repeat of the same lookup must still return them. A start raised mid-run is judged the same way: the result must match the first request's operands, and busy_o must not rise again after done_o.

// File: rtl/tbl_pkg.sv
package tbl_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/tbl_regfile.sv
module tbl_regfile #(
  parameter int NUM_REGS = 32,
  parameter int REG_W    = 128,
  parameter int ADDR_W   = 5
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [REG_W-1:0]  rdata_o
);
  logic [REG_W-1:0] rows [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_row
    logic [REG_W-1:0] row_q;
    always_ff @(posedge clk_i) begin
      if (we_i && waddr_i == ADDR_W'(r)) row_q <= wdata_i;
    end
    assign rows[r] = row_q;
  end

  assign rdata_o = rows[raddr_i];
endmodule

// File: rtl/tbl_index_map.sv
module tbl_index_map import tbl_pkg::*; #(
  parameter int ADDR_W    = 5,
  parameter int REG_BYTES = 16,
  parameter int CNT_W     = 3,
  localparam int SEL_W    = $clog2(REG_BYTES),
  localparam int HALF_SH  = SEL_W - 1,
  localparam int ELEM_W   = ADDR_W + 1,
  localparam int CMP_W    = BYTE_W + CNT_W + SEL_W
) (
  input  byte_t             idx_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [SEL_W-1:0]  byte_sel_o
);
  logic [ELEM_W-1:0] elem;

  // element index wraps naturally at 2*NUM_REGS
  assign elem       = {base_i, 1'b0} + ELEM_W'(idx_i >> HALF_SH);
  assign rd_addr_o  = elem[ELEM_W-1:1];
  assign byte_sel_o = {elem[0], idx_i[HALF_SH-1:0]};
  assign hit_o      = CMP_W'(idx_i) < (CMP_W'(cnt_i) * CMP_W'(REG_BYTES));
endmodule

// File: rtl/tbl_seq.sv
module tbl_seq #(
  parameter int LANES   = 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              accept_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [LANE_W-1:0] lane_o
);
  logic              busy_q, done_q;
  logic [LANE_W-1:0] lane_q;

  assign accept_o = start_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      lane_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept_o) begin
        busy_q <= 1'b1;
        lane_q <= '0;
      end else if (busy_q) begin
        lane_q <= lane_q + 1'b1;
        if (lane_q == LANE_W'(LANES - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign lane_o = lane_q;
endmodule

// File: rtl/byte_tbl_lookup.sv
module byte_tbl_lookup import tbl_pkg::*; #(
  parameter int NUM_REGS  = 32,
  parameter int REG_BYTES = 16,
  parameter int LANES     = 8,
  parameter int CNT_W     = 3,
  localparam int ADDR_W   = $clog2(NUM_REGS),
  localparam int REG_W    = REG_BYTES * BYTE_W,
  localparam int IDX_W    = LANES * BYTE_W,
  localparam int LANE_W   = $clog2(LANES),
  localparam int SEL_W    = $clog2(REG_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [IDX_W-1:0]  init_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [IDX_W-1:0]  result_o
);
  logic              accept, busy;
  logic [LANE_W-1:0] lane;
  logic [IDX_W-1:0]  idx_q, res_q;
  logic [ADDR_W-1:0] base_q, rd_addr;
  logic [CNT_W-1:0]  cnt_q;
  logic [REG_W-1:0]  rd_data;
  logic [SEL_W-1:0]  byte_sel;
  logic              hit;
  byte_t             cur_idx, rd_byte;

  tbl_seq #(.LANES(LANES)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .accept_o (accept),
    .busy_o   (busy),
    .done_o   (done_o),
    .lane_o   (lane)
  );

  // register file is frozen while a lookup walks it
  tbl_regfile #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_rf (
    .clk_i   (clk_i),
    .we_i    (wr_en_i & ~busy),
    .waddr_i (wr_addr_i),
    .wdata_i (wr_data_i),
    .raddr_i (rd_addr),
    .rdata_o (rd_data)
  );

  assign cur_idx = idx_q[lane*BYTE_W +: BYTE_W];

  tbl_index_map #(.ADDR_W(ADDR_W), .REG_BYTES(REG_BYTES), .CNT_W(CNT_W)) u_map (
    .idx_i      (cur_idx),
    .base_i     (base_q),
    .cnt_i      (cnt_q),
    .hit_o      (hit),
    .rd_addr_o  (rd_addr),
    .byte_sel_o (byte_sel)
  );

  assign rd_byte = rd_data[byte_sel*BYTE_W +: BYTE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (accept) begin
      idx_q  <= idx_i;
      base_q <= base_i;
      cnt_q  <= count_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
    end else if (accept) begin
      res_q <= init_i;
    end else if (busy && hit) begin
      res_q[lane*BYTE_W +: BYTE_W] <= rd_byte;
    end
  end

  assign busy_o   = busy;
  assign result_o = res_q;
endmodule

// File: rtl/byte_tbl_lookup_chk.sv
module tbl_lookup_chk #(
  parameter int IDX_W = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [IDX_W-1:0] result_o
);
  logic [3:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else run_q <= '0;
  end

  a_r1_idle_after_reset: assert property (@(posedge clk_i) !rst_ni |-> !busy_o && !done_o);

  a_r2_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o);

  a_r2_busy_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> run_q <= 4'd7);

  a_r2_busy_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(run_q) == 4'd7);

  a_r2_done_follows_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));

  a_r2_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r3_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && run_q < 4'd7 |=> busy_o && !done_o);

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(result_o));
endmodule

bind byte_tbl_lookup tbl_lookup_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .result_o (result_o)
);

// File: tb/byte_tbl_lookup_tb.sv
module byte_tbl_lookup_tb;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         wr_en = 1'b0;
  logic [4:0]   wr_addr = '0;
  logic [127:0] wr_data = '0;
  logic         start = 1'b0;
  logic [63:0]  idx_in = '0;
  logic [4:0]   base_in = '0;
  logic [2:0]   cnt_in = '0;
  logic [63:0]  init_in = '0;
  logic         busy, done;
  logic [63:0]  result;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [127:0] mem [32];

  always #10 clk = ~clk;

  byte_tbl_lookup u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .start_i(start), .idx_i(idx_in), .base_i(base_in),
    .count_i(cnt_in), .init_i(init_in), .busy_o(busy), .done_o(done),
    .result_o(result)
  );

  task automatic chk(input bit cond, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int r, input int j);
    return 8'((r * 13) ^ (j * 29) ^ 8'h5a);
  endfunction

  function automatic logic [63:0] model(input logic [63:0] ix, input int base,
                                        input int cnt, input logic [63:0] init);
    logic [63:0] res = init;
    for (int l = 0; l < 8; l++) begin
      int v = int'(ix[8*l +: 8]);
      if (v < 16 * cnt) begin
        int e = (base * 2 + v / 8) % 64;
        int b = (e % 2) * 8 + v % 8;
        res[8*l +: 8] = mem[e / 2][8*b +: 8];
      end
    end
    return res;
  endfunction

  task automatic wr_reg(input int r, input logic [127:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(r); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    mem[r] = d;
  endtask

  // inject: 0 none, 1 start mid-run, 2 write mid-run, 3 write with start
  task automatic run_lookup(input logic [63:0] ix, input int base, input int cnt,
                            input logic [63:0] init, input int inject,
                            input int w_r, input logic [127:0] w_d,
                            output logic [63:0] res, output bit ok);
    @(negedge clk);
    start = 1'b1; idx_in = ix; base_in = 5'(base); cnt_in = 3'(cnt); init_in = init;
    if (inject == 3) begin wr_en = 1'b1; wr_addr = 5'(w_r); wr_data = w_d; end
    @(negedge clk);
    start = 1'b0; wr_en = 1'b0;
    ok = 1;
    for (int k = 0; k < 8; k++) begin
      if (!(busy && !done)) ok = 0;
      if (k == 3 && inject == 1) begin
        start = 1'b1; idx_in = ~ix; base_in = 5'(base + 1); init_in = ~init;
      end
      if (k == 3 && inject == 2) begin
        wr_en = 1'b1; wr_addr = 5'(w_r); wr_data = w_d;
      end
      @(negedge clk);
      start = 1'b0; wr_en = 1'b0;
    end
    if (!(done && !busy)) ok = 0;
    res = result;
    @(negedge clk);
    if (done || busy || result != res) ok = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] res, exp, ix, init;
    bit ok;

    repeat (3) @(negedge clk);
    chk(!busy && !done && result == 64'd0, "R1 reset state", {busy, done, result[61:0]}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!busy && !done && result == 64'd0, "R1 after release", result, 64'd0);

    for (int r = 0; r < 32; r++) begin
      logic [127:0] d;
      for (int j = 0; j < 16; j++) d[8*j +: 8] = pat(r, j);
      wr_reg(r, d);
    end

    // R4 R5 R7: sweep every base and count, mixed in/out-of-range lanes
    for (int b = 0; b < 32; b++) begin
      for (int c = 1; c <= 4; c++) begin
        for (int l = 0; l < 8; l++) ix[8*l +: 8] = 8'((b * 29 + c * 53 + l * 41) & 8'h7f);
        init = (b % 2 == 0) ? 64'd0 : (64'hfedc_ba98_7654_3210 ^ {8{3'(c), 5'(b)}});
        exp = model(ix, b, c, init);
        run_lookup(ix, b, c, init, 0, 0, '0, res, ok);
        chk(ok, "R2 timing", 64'(ok), 64'd1);
        chk(res == exp, "R5 R4 sweep", res, exp);
      end
    end

    // R6: every in-range index of a four-register table wrapping past register 31
    for (int b = 29; b < 32; b++) begin
      for (int g = 0; g < 9; g++) begin
        for (int l = 0; l < 8; l++) ix[8*l +: 8] = 8'(g * 8 + l);
        init = 64'h1111_2222_3333_4444;
        exp = model(ix, b, 4, init);
        run_lookup(ix, b, 4, init, 0, 0, '0, res, ok);
        chk(res == exp, "R6 wrap", res, exp);
      end
    end

    // R4: boundary of a one-register table
    ix = {8'd0, 8'd255, 8'd17, 8'd16, 8'd15, 8'd8, 8'd7, 8'd0};
    init = 64'haaaa_aaaa_aaaa_aaaa;
    exp = {pat(9, 0), 8'haa, 8'haa, 8'haa, pat(9, 15), pat(9, 8), pat(9, 7), pat(9, 0)};
    run_lookup(ix, 9, 1, init, 0, 0, '0, res, ok);
    chk(res == exp, "R4 boundary", res, exp);

    // R7: lane placement with distinct indices per lane
    ix = {8'd7, 8'd6, 8'd5, 8'd4, 8'd3, 8'd2, 8'd1, 8'd0};
    exp = {pat(4, 7), pat(4, 6), pat(4, 5), pat(4, 4), pat(4, 3), pat(4, 2), pat(4, 1), pat(4, 0)};
    run_lookup(ix, 4, 1, 64'd0, 0, 0, '0, res, ok);
    chk(res == exp, "R7 lane order", res, exp);

    // R3: start raised mid-run is ignored
    ix = 64'h0f1e_2d3c_0b1a_2938;
    init = 64'h0123_4567_89ab_cdef;
    exp = model(ix, 12, 4, init);
    run_lookup(ix, 12, 4, init, 1, 0, '0, res, ok);
    chk(ok, "R3 no restart", 64'(ok), 64'd1);
    chk(res == exp, "R3 operands kept", res, exp);

    // R8: write during busy dropped
    ix = {8'd15, 8'd14, 8'd13, 8'd12, 8'd3, 8'd2, 8'd1, 8'd0};
    exp = model(ix, 5, 1, 64'd0);
    run_lookup(ix, 5, 1, 64'd0, 2, 5, {128{1'b1}}, res, ok);
    chk(res == exp, "R8 busy write", res, exp);
    run_lookup(ix, 5, 1, 64'd0, 0, 0, '0, res, ok);
    chk(res == exp, "R8 register unchanged", res, exp);

    // R8: write in the same cycle as an accepted start is seen
    mem[6] = 128'h0f0e_0d0c_0b0a_0908_0706_0504_0302_0100;
    exp = model(ix, 6, 1, 64'd0);
    run_lookup(ix, 6, 1, 64'd0, 3, 6, mem[6], res, ok);
    chk(res == exp, "R8 write with start", res, exp);

    // R9: result holds while idle
    repeat (5) @(negedge clk);
    chk(result == exp && !busy && !done, "R9 hold", result, exp);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule